// File: doc/BRIEF.md
# Tag Load-Modulation Encoder

This block converts a serial stream of data bits into the on/off control for a transponder's damping load. It runs on the field clock. It fetches one bit at a time from an upstream sequencer through a request strobe, and it shapes that bit into the selected line code.

The supported line codes are:

- plain level (NRZ)
- Manchester
- two biphase variants
- two frequency-shift variants with subcarriers of RF/5, RF/8 and RF/10
- three phase-shift variants on an RF/2 subcarrier

One bit lasts 2n+2 field clocks, where n is a 6-bit rate value. An inversion control flips every bit before it is encoded. On request, a two-bit start marker is sent ahead of a block sequence, and the marker alternates between `01` and `10` from one sequence to the next.

The core is a four-state sequencer:

- **IDLE** is entered by reset and lasts one cycle, with the request strobe high.
- **MARK_FIRST** and **MARK_SECOND** each send one marker bit.
- **DATA** sends the fetched bit.

The transitions are:

- **IDLE→DATA** and **DATA→DATA**: a bit is fetched with no sequence start, or with markers disabled.
- **IDLE→MARK_FIRST** and **DATA→MARK_FIRST**: the fetched bit is flagged as a sequence start while markers are enabled. The bit is parked until the markers have been sent.
- **MARK_FIRST→MARK_SECOND**: the first marker period ends.
- **MARK_SECOND→DATA**: the second marker period ends, and the parked bit is sent.

The upstream logic presents `data_in` and `seq_start` while `bit_req` is high. Both are taken at the next clock edge, and the new bit period starts on the cycle after that edge.

Top module: `tag_mod_encoder`

## Requirements
- R1: A bit period is exactly 2n+2 field clocks, where n is `rate_n` (0 to 63). `bit_req` is high only in the last cycle of a period that carries a data bit. The cycle after the edge that takes a bit is cycle 0 of that bit.
- R2: Mode code 0 (NRZ): `damp` equals the encoded bit for the whole period.
- R3: Mode code 1 (Manchester): cycles 0..n drive the inverse of the encoded bit and cycles n+1..2n+1 drive the bit itself. A 0 therefore falls at mid-bit and a 1 rises at mid-bit.
- R4: Mode codes 2 and 3 (biphase): the level toggles at the start of every bit. It toggles again at cycle n+1 when the bit is 1 (code 2) or when the bit is 0 (code 3). The level is 0 after reset.
- R5: Mode codes 4 and 5 (FSK): code 4 uses a period of 5 clocks for a 0 and 8 for a 1; code 5 uses 10 for a 0 and 8 for a 1. `damp` is high for the first floor(period/2) clocks of each subcarrier cycle. The subcarrier restarts at every bit start.
- R6: Mode codes 6, 7 and 8 (PSK): `damp` is the RF/2 subcarrier, equal to (cycle index mod 2) XOR phase. At a bit start the phase flips in these cases:
  - code 6: the new bit differs from the previous bit.
  - code 7: the new bit is 1.
  - code 8: the previous bit is 0 and the new bit is 1.
  The phase and the previous bit are both 0 after reset.
- R7: With `inv_en` high, each bit, marker bits included, is inverted before encoding in every mode. `inv_en` is sampled when the bit is taken.
- R8: With `marker_en` high, a bit taken with `seq_start` high is preceded by two marker bit periods. The first marker after reset is 0 then 1, and each later marker is the inverse of the one before it. `bit_req` stays low during marker periods. With `marker_en` low, `seq_start` has no effect.
- R9: While reset is held and in the IDLE cycle after it, `damp` is 0 and `bit_req` is 1.
- R10: Mode codes 9 to 15 keep `damp` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 1 | Next data bit, taken when `bit_req` is high |
| seq_start | input | 1 | Flags the offered bit as the first of a block sequence |
| mod_sel | input | 4 | Line-code select, codes 0 to 8 |
| inv_en | input | 1 | Invert bits before encoding |
| marker_en | input | 1 | Enable the two-bit start marker |
| rate_n | input | RATE_W | Rate value n; the bit period is 2n+2 clocks |
| damp | output | 1 | Damping load control |
| bit_req | output | 1 | Requests the next data bit |

## Verification
The bound checker enforces several rules on every cycle:

- Requests never appear on two adjacent cycles.
- IDLE is silent and keeps its request high.
- No request appears in a marker state.
- NRZ holds its level inside a bit.
- Manchester always changes level at mid-bit.
- PSK toggles on every clock inside a bit.

Some behaviours depend on the data history, so only the directed scenarios can show them:

- the PSK phase rules
- the biphase level carried from one bit to the next
- the FSK subcarrier periods and their restart at each bit
- the exact inversion result
- the alternation of the marker value

The bench compares the full waveform of each scenario against a model of these rules.

// File: rtl/tag_mod_pkg.sv
package tag_mod_pkg;

    typedef enum logic [3:0] {
        MOD_NRZ    = 4'd0,
        MOD_MANCH  = 4'd1,
        MOD_BIPH_A = 4'd2,
        MOD_BIPH_B = 4'd3,
        MOD_FSK_A  = 4'd4,
        MOD_FSK_B  = 4'd5,
        MOD_PSK_A  = 4'd6,
        MOD_PSK_B  = 4'd7,
        MOD_PSK_C  = 4'd8
    } mod_t;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_MARK_FIRST  = 2'd1,
        ST_MARK_SECOND = 2'd2,
        ST_DATA        = 2'd3
    } seq_state_t;

    localparam int FSK_SHORT = 5;
    localparam int FSK_MID   = 8;
    localparam int FSK_LONG  = 10;

endpackage

// File: rtl/tmenc_bit_timer.sv
module tmenc_bit_timer #(
    parameter int RATE_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [RATE_W-1:0]   rate_n,
    output logic [RATE_W:0]     cnt,
    output logic                bit_last,
    output logic                mid_last,
    output logic                first_half
);
    localparam int CNT_W = RATE_W + 1;

    logic [CNT_W-1:0] half_idx;
    logic [CNT_W-1:0] last_idx;

    assign half_idx   = {1'b0, rate_n};
    assign last_idx   = {rate_n, 1'b1};
    assign bit_last   = run && (cnt >= last_idx);
    assign mid_last   = run && (cnt == half_idx);
    assign first_half = (cnt <= half_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || bit_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmenc_fsk_gen.sv
module tmenc_fsk_gen #(
    parameter int P_ZERO_A = 5,
    parameter int P_ONE    = 8,
    parameter int P_ZERO_B = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic use_b,
    input  logic bit_val,
    output logic sub
);
    localparam int SC_W = $clog2(P_ZERO_B + 1);

    logic [SC_W-1:0] sc;
    logic [SC_W-1:0] period;

    always_comb begin
        if (bit_val) begin
            period = SC_W'(P_ONE);
        end else if (use_b) begin
            period = SC_W'(P_ZERO_B);
        end else begin
            period = SC_W'(P_ZERO_A);
        end
    end

    assign sub = (sc < (period >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc <= '0;
        end else if (restart || (sc >= period - 1'b1)) begin
            sc <= '0;
        end else begin
            sc <= sc + 1'b1;
        end
    end

endmodule

// File: rtl/tmenc_line_coder.sv
module tmenc_line_coder
    import tag_mod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic load,
    input  logic mid_last,
    input  logic first_half,
    input  logic cnt0,
    input  mod_t mode,
    input  logic new_bit,
    output logic damp
);
    logic cur;
    logic lvl;
    logic phase;
    logic fsk_sub;

    tmenc_fsk_gen #(
        .P_ZERO_A (FSK_SHORT),
        .P_ONE    (FSK_MID),
        .P_ZERO_B (FSK_LONG)
    ) u_fsk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .use_b   (mode == MOD_FSK_B),
        .bit_val (cur),
        .sub     (fsk_sub)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= 1'b0;
            lvl   <= 1'b0;
            phase <= 1'b0;
        end else if (load) begin
            cur <= new_bit;
            lvl <= ~lvl;
            case (mode)
                MOD_PSK_A: phase <= phase ^ (cur ^ new_bit);
                MOD_PSK_B: phase <= phase ^ new_bit;
                MOD_PSK_C: phase <= phase ^ (~cur & new_bit);
                default:   phase <= phase;
            endcase
        end else if (mid_last) begin
            if ((mode == MOD_BIPH_A && cur) || (mode == MOD_BIPH_B && !cur)) begin
                lvl <= ~lvl;
            end
        end
    end

    always_comb begin
        damp = 1'b0;
        if (active) begin
            unique case (mode)
                MOD_NRZ:                        damp = cur;
                MOD_MANCH:                      damp = first_half ? ~cur : cur;
                MOD_BIPH_A, MOD_BIPH_B:         damp = lvl;
                MOD_FSK_A, MOD_FSK_B:           damp = fsk_sub;
                MOD_PSK_A, MOD_PSK_B, MOD_PSK_C: damp = cnt0 ^ phase;
                default:                        damp = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tag_mod_encoder.sv
module tag_mod_encoder
    import tag_mod_pkg::*;
#(
    parameter int RATE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_in,
    input  logic              seq_start,
    input  logic [3:0]        mod_sel,
    input  logic              inv_en,
    input  logic              marker_en,
    input  logic [RATE_W-1:0] rate_n,
    output logic              damp,
    output logic              bit_req
);
    localparam int CNT_W = RATE_W + 1;

    seq_state_t       state_q, state_d;
    logic             cur_q, cur_d;
    logic             pend_q, pend_d;
    logic             pol_q, pol_d;
    logic [CNT_W-1:0] bit_cnt;
    logic             bit_last, mid_last, first_half;
    logic             run, boundary;
    mod_t             mode;

    assign mode     = mod_t'(mod_sel);
    assign run      = (state_q != ST_IDLE);
    assign boundary = !run || bit_last;

    tmenc_bit_timer #(.RATE_W(RATE_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .rate_n     (rate_n),
        .cnt        (bit_cnt),
        .bit_last   (bit_last),
        .mid_last   (mid_last),
        .first_half (first_half)
    );

    // next-state and next-bit selection
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        pend_d  = pend_q;
        pol_d   = pol_q;
        if (boundary) begin
            unique case (state_q)
                ST_IDLE, ST_DATA: begin
                    if (marker_en && seq_start) begin
                        state_d = ST_MARK_FIRST;
                        cur_d   = pol_q;
                        pend_d  = data_in;
                        pol_d   = ~pol_q;
                    end else begin
                        state_d = ST_DATA;
                        cur_d   = data_in;
                    end
                end
                ST_MARK_FIRST: begin
                    state_d = ST_MARK_SECOND;
                    cur_d   = ~cur_q;
                end
                ST_MARK_SECOND: begin
                    state_d = ST_DATA;
                    cur_d   = pend_q;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= 1'b0;
            pend_q  <= 1'b0;
            pol_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            pend_q  <= pend_d;
            pol_q   <= pol_d;
        end
    end

    // outputs
    always_comb begin
        bit_req = boundary && (state_q == ST_IDLE || state_q == ST_DATA);
    end

    tmenc_line_coder u_coder (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (run),
        .load       (boundary),
        .mid_last   (mid_last),
        .first_half (first_half),
        .cnt0       (bit_cnt[0]),
        .mode       (mode),
        .new_bit    (cur_d ^ inv_en),
        .damp       (damp)
    );

endmodule

// File: rtl/tag_mod_encoder_chk.sv
module tag_mod_encoder_chk
    import tag_mod_pkg::*;
#(
    parameter int RATE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        mod_sel,
    input logic [RATE_W-1:0] rate_n,
    input logic              damp,
    input logic              bit_req,
    input seq_state_t        st,
    input logic [RATE_W:0]   cnt
);
    logic is_psk;
    assign is_psk = (mod_sel == MOD_PSK_A) || (mod_sel == MOD_PSK_B) || (mod_sel == MOD_PSK_C);

    assert_req_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req |=> !bit_req);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!damp && bit_req));

    assert_nrz_flat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel == MOD_NRZ && $stable(mod_sel) && cnt != '0) |-> $stable(damp));

    assert_manch_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel == MOD_MANCH && $stable(mod_sel) && $stable(rate_n) && st != ST_IDLE
         && cnt == ({1'b0, rate_n} + 1'b1)) |-> (damp != $past(damp)));

    assert_psk_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_psk && $stable(mod_sel) && cnt != '0) |-> (damp != $past(damp)));

    assert_marker_noreq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MARK_FIRST || st == ST_MARK_SECOND) |-> !bit_req);

endmodule

bind tag_mod_encoder tag_mod_encoder_chk #(.RATE_W(RATE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_sel (mod_sel),
    .rate_n  (rate_n),
    .damp    (damp),
    .bit_req (bit_req),
    .st      (state_q),
    .cnt     (bit_cnt)
);

// File: tb/tag_mod_encoder_test.sv
module tag_mod_encoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int RW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          data_in = 1'b0;
    logic          seq_start = 1'b0;
    logic [3:0]    mod_sel = 4'd0;
    logic          inv_en = 1'b0;
    logic          marker_en = 1'b0;
    logic [RW-1:0] rate_n = '0;
    logic          damp;
    logic          bit_req;

    int n_tests = 0;
    int n_fail  = 0;

    logic got_d [0:4095];
    logic got_r [0:4095];
    logic sym    [0:31];
    logic sym_mk [0:31];
    int   n_sym;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_mod_encoder #(.RATE_W(RW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .seq_start (seq_start),
        .mod_sel   (mod_sel),
        .inv_en    (inv_en),
        .marker_en (marker_en),
        .rate_n    (rate_n),
        .damp      (damp),
        .bit_req   (bit_req)
    );

    task automatic build_syms(input logic [15:0] bits, input logic [15:0] seqs,
                              input int nb, input bit mark);
        bit pol;
        pol = 1'b0;
        n_sym = 0;
        for (int i = 0; i < nb; i++) begin
            if (mark && seqs[i]) begin
                sym[n_sym] = pol;      sym_mk[n_sym] = 1'b1;
                sym[n_sym+1] = ~pol;   sym_mk[n_sym+1] = 1'b1;
                n_sym += 2;
                pol = ~pol;
            end
            sym[n_sym] = bits[i];
            sym_mk[n_sym] = 1'b0;
            n_sym++;
        end
    endtask

    // reset, stream the bits, then compare against the rules of R1..R10
    task automatic run_case(input logic [3:0] mode, input bit inv, input bit mark,
                            input int n, input logic [15:0] bits, input logic [15:0] seqs,
                            input int nb, input string req);
        int p, total, idx, c, pf, first_bad, rbad;
        logic prevb, lvl, ph, b, e, ae, ee, re, ra;
        p = 2*n + 2;
        build_syms(bits, seqs, nb, mark);
        total = n_sym * p;
        rst_n = 1'b0; mod_sel = mode; inv_en = inv; marker_en = mark;
        rate_n = n[RW-1:0]; data_in = 1'b0; seq_start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        data_in = bits[0]; seq_start = seqs[0]; idx = 1;
        for (int cy = 0; cy < total; cy++) begin
            @(negedge clk);
            got_d[cy] = damp;
            got_r[cy] = bit_req;
            if (bit_req) begin
                if (idx < nb) begin
                    data_in = bits[idx]; seq_start = seqs[idx];
                end else begin
                    data_in = 1'b0; seq_start = 1'b0;
                end
                idx++;
            end
        end
        prevb = 1'b0; lvl = 1'b0; ph = 1'b0; rbad = -1; ra = 1'b0; re = 1'b0;
        for (int j = 0; j < n_sym; j++) begin
            b = sym[j] ^ inv;
            lvl = ~lvl;
            case (mode)
                4'd6: ph = ph ^ (prevb ^ b);
                4'd7: ph = ph ^ b;
                4'd8: ph = ph ^ (~prevb & b);
                default: ph = ph;
            endcase
            prevb = b;
            pf = (mode == 4'd4) ? (b ? 8 : 5) : (b ? 8 : 10);
            first_bad = -1; ae = 1'b0; ee = 1'b0;
            for (int k = 0; k < p; k++) begin
                if (k == n + 1 && ((mode == 4'd2 && b) || (mode == 4'd3 && !b))) lvl = ~lvl;
                case (mode)
                    4'd0: e = b;
                    4'd1: e = (k <= n) ? ~b : b;
                    4'd2, 4'd3: e = lvl;
                    4'd4, 4'd5: e = ((k % pf) < (pf / 2));
                    4'd6, 4'd7, 4'd8: e = ((k % 2) == 1) ^ ph;
                    default: e = 1'b0;
                endcase
                c = j*p + k;
                if (got_d[c] !== e && first_bad < 0) begin
                    first_bad = k; ae = got_d[c]; ee = e;
                end
                if (got_r[c] !== ((k == p-1) && !sym_mk[j]) && rbad < 0) begin
                    rbad = c; ra = got_r[c]; re = (k == p-1) && !sym_mk[j];
                end
            end
            n_tests++;
            if (first_bad >= 0) begin
                n_fail++;
                $display("FAIL %s: mode %0d symbol %0d cycle %0d damp=%b expected %b",
                         req, mode, j, first_bad, ae, ee);
            end
        end
        n_tests++;
        if (rbad >= 0) begin
            n_fail++;
            $display("FAIL R1 (%s) bit_req at cycle %0d: got %b expected %b", req, rbad, ra, re);
        end
    endtask

    task automatic t_reset_R9();
        rst_n = 1'b0; mod_sel = 4'd1; inv_en = 1'b1; marker_en = 1'b1; seq_start = 1'b1;
        repeat (3) @(negedge clk);
        n_tests++;
        if (damp !== 1'b0 || bit_req !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 in reset: damp=%b bit_req=%b expected 0 1", damp, bit_req);
        end
        rst_n = 1'b1;
        #1;
        n_tests++;
        if (damp !== 1'b0 || bit_req !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 idle: damp=%b bit_req=%b expected 0 1", damp, bit_req);
        end
        seq_start = 1'b0;
    endtask

    task automatic t_timing_R1();
        run_case(4'd0, 1'b0, 1'b0, 0,  16'b0110_1001, 16'd0, 8, "R1");
        run_case(4'd0, 1'b0, 1'b0, 63, 16'b101,       16'd0, 3, "R1");
        run_case(4'd0, 1'b0, 1'b0, 5,  16'b1100,      16'd0, 4, "R1");
    endtask

    task automatic t_nrz_R2();
        run_case(4'd0, 1'b0, 1'b0, 3, 16'b1011_0010, 16'd0, 8, "R2");
    endtask

    task automatic t_manch_R3();
        run_case(4'd1, 1'b0, 1'b0, 3, 16'b1001_1101, 16'd0, 8, "R3");
        run_case(4'd1, 1'b0, 1'b0, 0, 16'b0011_0101, 16'd0, 8, "R3");
    endtask

    task automatic t_biphase_R4();
        run_case(4'd2, 1'b0, 1'b0, 4, 16'b1100_1010, 16'd0, 8, "R4");
        run_case(4'd3, 1'b0, 1'b0, 4, 16'b1100_1010, 16'd0, 8, "R4");
    endtask

    task automatic t_fsk_R5();
        run_case(4'd4, 1'b0, 1'b0, 19, 16'b0110_0101, 16'd0, 8, "R5");
        run_case(4'd5, 1'b0, 1'b0, 19, 16'b0110_0101, 16'd0, 8, "R5");
        run_case(4'd4, 1'b0, 1'b0, 4,  16'b1001_0011, 16'd0, 8, "R5");
    endtask

    task automatic t_psk_R6();
        run_case(4'd6, 1'b0, 1'b0, 7, 16'b1110_0100, 16'd0, 8, "R6");
        run_case(4'd7, 1'b0, 1'b0, 7, 16'b1110_0100, 16'd0, 8, "R6");
        run_case(4'd8, 1'b0, 1'b0, 7, 16'b1110_0100, 16'd0, 8, "R6");
    endtask

    task automatic t_invert_R7();
        run_case(4'd0, 1'b1, 1'b0, 2, 16'b1011_0010, 16'd0, 8, "R7");
        run_case(4'd1, 1'b1, 1'b0, 3, 16'b1011_0010, 16'd0, 8, "R7");
        run_case(4'd5, 1'b1, 1'b0, 19, 16'b0011,     16'd0, 4, "R7");
        run_case(4'd7, 1'b1, 1'b0, 7, 16'b1110_0100, 16'd0, 8, "R7");
        run_case(4'd3, 1'b1, 1'b1, 4, 16'b0110_1100, 16'b0001_0001, 8, "R7");
    endtask

    task automatic t_marker_R8();
        run_case(4'd0, 1'b0, 1'b1, 3, 16'b1011_0110, 16'b0001_0001, 8, "R8");
        run_case(4'd1, 1'b0, 1'b1, 2, 16'b0101_1001, 16'b0010_0101, 8, "R8");
        run_case(4'd0, 1'b0, 1'b0, 3, 16'b1011_0110, 16'b0001_0001, 8, "R8");
    endtask

    task automatic t_reserved_R10();
        run_case(4'd9,  1'b0, 1'b0, 2, 16'b1101, 16'd0, 4, "R10");
        run_case(4'd15, 1'b1, 1'b0, 2, 16'b0010, 16'd0, 4, "R10");
    endtask

    initial begin
        t_reset_R9();
        t_timing_R1();
        t_nrz_R2();
        t_manch_R3();
        t_biphase_R4();
        t_fsk_R5();
        t_psk_R6();
        t_invert_R7();
        t_marker_R8();
        t_reserved_R10();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule